// File: doc/BRIEF.md
# Sound Status and Enable Register

This block is the single bus-visible control point of a five-channel sound generator. A bus write to its address loads five channel enable bits: one per pulse voice, one for the triangle voice, one for the noise voice and one for the sample-playback voice. A bus read at the same address returns a status byte. That byte combines live activity inputs from the channel length counters and the sample fetcher with two sticky interrupt flags that the block holds itself.

The frame-sequencer flag is set by a one-cycle pulse from the sequencer and is cleared by a destructive read. The sample-channel flag is set by a pulse from the sample fetcher and is cleared by any write. A debug peek strobe returns the same byte and leaves both flags untouched. The interrupt request output is high while either flag is set. When a set pulse and a clear arrive in the same cycle, the set wins, so no event is lost.

Top module: `snd_status_reg`

## Requirements
- R1: Read data bits 3:0 equal `len_active[3:0]` in the same cycle (bit 0 first pulse, bit 1 second pulse, bit 2 triangle, bit 3 noise).
- R2: Read data bit 4 equals `smp_bytes_left` in the same cycle.
- R3: Read data bit 6 is the frame interrupt flag, bit 7 is the sample interrupt flag, and bit 5 is always 0.
- R4: A read strobe at the block address returns the current frame flag, and the flag reads 0 from the next cycle on unless a set pulse arrives.
- R5: A write at the block address loads `chan_en` from `bus_wdata[4:0]` (bit 0 first pulse, bit 1 second pulse, bit 2 triangle, bit 3 noise, bit 4 sample) on the next cycle. Bits 7:5 are ignored.
- R6: A write at the block address clears the sample interrupt flag from the next cycle on, whatever the data.
- R7: `irq` is high exactly when at least one of the two flags is set.
- R8: A set pulse in the same cycle as a clearing access leaves the flag set.
- R9: A peek strobe returns the same byte as a read and clears no flag.
- R10: After reset both flags are 0, `chan_en` is 0 and `irq` is low.
- R11: Accesses to any other address return 0 and change no state.
- R12: A set pulse makes its flag 1 on the next cycle, and the flag stays 1 until a clearing access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Access address |
| bus_rd | input | 1 | Destructive read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_peek | input | 1 | Non-destructive read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Status byte while addressed by a read or a peek, else 0 |
| len_active | input | 4 | Length counter nonzero, per tone voice |
| smp_bytes_left | input | 1 | Sample fetcher has bytes remaining |
| frame_irq_set | input | 1 | One-cycle pulse that sets the frame flag |
| smp_irq_set | input | 1 | One-cycle pulse that sets the sample flag |
| chan_en | output | 5 | Channel enables |
| irq | output | 1 | Combined interrupt request |

## Verification
The assertions assume that `bus_rd` and `bus_wr` are never high in the same cycle, and that the set pulses are synchronous to `clk`. The stimulus draws one access kind per cycle (read, write, peek, peek with read, or idle), so the two bus strobes never overlap. Set pulses are drawn freely, so they regularly coincide with clearing accesses. About one access in six goes to a foreign address.

// File: rtl/snd_status_pkg.sv
package snd_status_pkg;
  localparam int DATA_W   = 8;
  localparam int TONE_N   = 4;
  localparam int EN_W     = TONE_N + 1;
  localparam int POS_LEFT = 4;
  localparam int POS_ZERO = 5;
  localparam int POS_FRM  = 6;
  localparam int POS_SMP  = 7;
  localparam int FLAG_N   = 2;
  localparam int IDX_FRM  = 0;
  localparam int IDX_SMP  = 1;

  function automatic logic [DATA_W-1:0] compose_status(
    input logic [TONE_N-1:0] act,
    input logic              left,
    input logic              frm,
    input logic              smp
  );
    logic [DATA_W-1:0] b;
    b = '0;
    b[TONE_N-1:0] = act;
    b[POS_LEFT]   = left;
    b[POS_ZERO]   = 1'b0;
    b[POS_FRM]    = frm;
    b[POS_SMP]    = smp;
    return b;
  endfunction
endpackage

// File: rtl/sts_decode.sv
module sts_decode #(
  parameter int ADDR_W = 5,
  parameter logic [ADDR_W-1:0] BASE = '0
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd,
  input  logic              wr,
  input  logic              peek,
  output logic              rd_hit,
  output logic              wr_hit,
  output logic              view_hit
);
  logic match;
  assign match    = (addr == BASE);
  assign rd_hit   = match & rd;
  assign wr_hit   = match & wr;
  assign view_hit = match & (rd | peek);
endmodule

// File: rtl/sts_flag.sv
module sts_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     flag_o <= 1'b0;
    else if (set_i) flag_o <= 1'b1;
    else if (clr_i) flag_o <= 1'b0;
  end

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n) set_i |=> flag_o); // R8
  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n) (clr_i && !set_i) |=> !flag_o); // R4
  AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (!clr_i && !set_i) |=> $stable(flag_o)); // R12
endmodule

// File: rtl/sts_enable_reg.sv
module sts_enable_reg #(
  parameter int DATA_W = 8,
  parameter int EN_W   = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] wdata,
  output logic [EN_W-1:0]   en
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    en <= '0;
    else if (load) en <= wdata[EN_W-1:0];
  end

  AST_EN_LOAD: assert property (@(posedge clk) disable iff (!rst_n) load |=> en == $past(wdata[EN_W-1:0])); // R5
  AST_EN_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !load |=> $stable(en)); // R11
endmodule

// File: rtl/snd_status_reg.sv
module snd_status_reg
  import snd_status_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter logic [ADDR_W-1:0] BASE = 5'h15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic              bus_peek,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [TONE_N-1:0] len_active,
  input  logic              smp_bytes_left,
  input  logic              frame_irq_set,
  input  logic              smp_irq_set,
  output logic [EN_W-1:0]   chan_en,
  output logic              irq
);
  logic rd_hit, wr_hit, view_hit;
  logic [FLAG_N-1:0] flag_set, flag_clr, flags;
  logic [DATA_W-1:0] status_byte;

  sts_decode #(.ADDR_W(ADDR_W), .BASE(BASE)) u_dec (
    .addr(bus_addr), .rd(bus_rd), .wr(bus_wr), .peek(bus_peek),
    .rd_hit(rd_hit), .wr_hit(wr_hit), .view_hit(view_hit)
  );

  assign flag_set[IDX_FRM] = frame_irq_set;
  assign flag_clr[IDX_FRM] = rd_hit;
  assign flag_set[IDX_SMP] = smp_irq_set;
  assign flag_clr[IDX_SMP] = wr_hit;

  for (genvar g = 0; g < FLAG_N; g++) begin : g_flag
    sts_flag u_flag (
      .clk(clk), .rst_n(rst_n),
      .set_i(flag_set[g]), .clr_i(flag_clr[g]), .flag_o(flags[g])
    );
  end

  sts_enable_reg #(.DATA_W(DATA_W), .EN_W(EN_W)) u_en (
    .clk(clk), .rst_n(rst_n), .load(wr_hit), .wdata(bus_wdata), .en(chan_en)
  );

  assign status_byte = compose_status(len_active, smp_bytes_left, flags[IDX_FRM], flags[IDX_SMP]);
  assign bus_rdata   = view_hit ? status_byte : '0;
  assign irq         = |flags;

  AST_NO_CLEAR_ON_PEEK: assert property (@(posedge clk) disable iff (!rst_n)
    (!(bus_rd || bus_wr) && bus_rdata[POS_FRM]) |=> irq); // R9
  AST_WRITE_DROPS_SMP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && !smp_irq_set && !frame_irq_set && !bus_rdata[POS_FRM] && !flags[IDX_FRM]) |=> !irq); // R6
  AST_RD_ONLY_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rdata != '0) |-> (bus_addr == BASE)); // R11
  AST_ZERO_BIT: assert property (@(posedge clk) disable iff (!rst_n) !bus_rdata[POS_ZERO]); // R3
  AST_BUS_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(bus_rd && bus_wr)); // R5
endmodule

// File: tb/sim_snd_status_reg.sv
module sim_snd_status_reg;
  logic clk = 0, rst_n = 0;
  logic [4:0] bus_addr = 0;
  logic bus_rd = 0, bus_wr = 0, bus_peek = 0;
  logic [7:0] bus_wdata = 0, bus_rdata;
  logic [3:0] len_active = 0;
  logic smp_bytes_left = 0, frame_irq_set = 0, smp_irq_set = 0;
  logic [4:0] chan_en;
  logic irq;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;
  int m_frm = 0, m_smp = 0, m_en = 0;

  always #5 clk = ~clk;

  snd_status_reg u0 (.*);

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input int a, input bit rd, input bit wr, input bit pk, input int wd,
                      input int act, input bit left, input bit fs, input bit ss);
    bit hit, view;
    int exp_b;
    @(negedge clk);
    bus_addr = a[4:0]; bus_rd = rd; bus_wr = wr; bus_peek = pk; bus_wdata = wd[7:0];
    len_active = act[3:0]; smp_bytes_left = left; frame_irq_set = fs; smp_irq_set = ss;
    #1;
    hit  = (a == 'h15);
    view = hit && (rd || pk);
    if (view) begin
      exp_b = act | (int'(left) << 4) | (m_frm << 6) | (m_smp << 7);
      check("R1", bus_rdata[3:0], exp_b & 'hF);
      check("R2", bus_rdata[4], (exp_b >> 4) & 1);
      check("R3", bus_rdata[7:5], (exp_b >> 5) & 7);
      if (pk && !rd) check("R9", bus_rdata, exp_b);
    end else begin
      check("R11", bus_rdata, 0);
    end
    check("R7", irq, (m_frm | m_smp));
    check("R5", chan_en, m_en);
    if (fs) m_frm = 1; else if (hit && rd) m_frm = 0;
    if (ss) m_smp = 1; else if (hit && wr) m_smp = 0;
    if (hit && wr) m_en = wd & 'h1F;
  endtask

  initial begin
    #2000000;
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R10", chan_en, 0);
    check("R10", irq, 0);
    rst_n = 1;
    // R12: set pulse sets flag, sticky across idle cycles
    step('h15, 0, 0, 0, 0, 0, 0, 1, 0);
    step('h00, 0, 0, 0, 0, 0, 0, 0, 0);
    step('h15, 0, 0, 1, 0, 5, 1, 0, 0);   // R9 peek keeps flag
    step('h15, 1, 0, 0, 0, 5, 1, 0, 0);   // R4 read returns then clears
    step('h15, 0, 0, 1, 0, 0, 0, 0, 0);
    // R8: set and read together keep frame flag
    step('h15, 1, 0, 0, 0, 0, 0, 1, 0);
    step('h15, 1, 0, 0, 0, 0, 0, 1, 0);
    step('h15, 1, 0, 0, 0, 0, 0, 0, 0);
    // R6 / R8 on sample flag, R5 ignoring upper bits
    step('h15, 0, 0, 0, 0, 0, 0, 0, 1);
    step('h15, 0, 1, 0, 'hFF, 0, 0, 0, 1);
    step('h15, 0, 1, 0, 'hEA, 0, 0, 0, 0);
    step('h15, 0, 0, 1, 0, 'hF, 1, 0, 0);
    // R11: foreign address write and read do nothing
    step('h14, 0, 1, 0, 'h1F, 0, 0, 0, 0);
    step('h16, 1, 0, 0, 0, 'hF, 1, 0, 0);
    for (int i = 0; i < 3000; i++) begin
      int k = $urandom_range(0, 4);
      int a = ($urandom_range(0, 5) == 0) ? $urandom_range(0, 31) : 'h15;
      step(a, (k == 1) || (k == 4), k == 2, (k == 3) || (k == 4), $urandom_range(0, 255),
           $urandom_range(0, 15), $urandom_range(0, 1),
           $urandom_range(0, 5) == 0, $urandom_range(0, 5) == 0);
    end
    step('h15, 0, 0, 0, 0, 0, 0, 0, 0);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule